// File: doc/BRIEF.md
# GPIO-to-Interrupt-Line Source Selector

This block decides which GPIO port feeds each of sixteen external interrupt lines. Line x can only ever carry pin x. The only choice is the port, which a 4-bit code per line selects. Each 32-bit selector register holds four such codes. The routing from pins to lines is purely combinational, so an edge on the chosen pin reaches the interrupt controller downstream in the same cycle. Edge detection, masking and pending state sit in that controller, not here.

The block also holds a small control word for an I/O slew-rate compensation cell. Software sets an enable bit. A read-only ready flag then rises after a fixed, parameterized settling time. The flag drops one cycle after software clears the enable.

Software reaches the block through a simple write port and a read port. Both take byte offsets. Address bits 1:0 are ignored, and reads are combinational.

Top module: `irq_src_select`

## Requirements
- R1: After reset all sixteen selector codes are 0, the compensation enable and ready flag are 0, every selector and compensation read returns 0, and each line x follows pin x of port A.
- R2: Port code p (0 to 7, in the order A, B, C, D, E, F, G, H) routes pin x of port p to line x. Port p, pin x sits at bit p*16+x of `port_pins`.
- R3: A line whose code is 8 to 15 is driven to 0, whatever the pins do.
- R4: The selector registers sit at byte offsets 0x08, 0x0C, 0x10 and 0x14 and hold lines 0-3, 4-7, 8-11 and 12-15. Line 4r+k uses bits 4k+3:4k. Bits 31:16 read as 0.
- R5: Routing is combinational from the pins. A selector write changes the routing only after the clock edge that takes the write.
- R6: The compensation word at offset 0x20 has a writable enable in bit 0, which reads back and drives `comp_en`.
- R7: The ready flag is bit 8 of offset 0x20 and `comp_ready`. It rises exactly READY_DELAY clock edges after the edge that set the enable. Writing the enable to 1 again while it is already 1 does not restart the delay. Writes to bit 8 are ignored.
- R8: The ready flag clears on the clock edge after the one that clears the enable.
- R9: Offsets other than 0x08, 0x0C, 0x10, 0x14 and 0x20 read as 0. Writes to them change no selector and no enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_pins | input | 128 | Pin levels of ports A..H, 16 pins each, port p at bits 16p+15:16p |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 6 | Read byte offset |
| rd_data | output | 32 | Read data for `rd_addr` |
| irq_line | output | 16 | Interrupt source lines, line x = pin x of the selected port |
| comp_en | output | 1 | Compensation cell enable |
| comp_ready | output | 1 | Compensation cell ready flag |

## Verification
The routing is tried with three kinds of selector setting. In the first, every line uses the same code. In the second, each line uses a different code. The third uses random codes, including codes 8 to 15, with fresh random pin levels on every pass. Uniform codes show that each port code picks the right port. Differing codes catch a wrong field position or the wrong register for a line. Random pins with out-of-range codes separate a line forced to zero from a line that only happens to read a low pin. The compensation flag is timed edge by edge, both to its rise and to its clear. Writes to unmapped offsets and to bit 8 are checked by reading every register back and by watching the lines.

// File: rtl/irq_src_select_pkg.sv
package irq_src_select_pkg;
  // Word indices (byte offset / 4) of the register map; decoding depends on them.
  localparam int SEL_BASE_WORD = 2;   // 0x08
  localparam int COMP_WORD     = 8;   // 0x20
  localparam int SEL_SPAN      = 16;  // low bits of a selector register that hold codes
  localparam int COMP_EN_BIT   = 0;
  localparam int COMP_RDY_BIT  = 8;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_SEL  = 2'd1,
    ACC_COMP = 2'd2
  } acc_kind_e;

  // Classifies a word index against the register map.
  function automatic acc_kind_e classify_word(input int word, input int num_sel_regs);
    if (word >= SEL_BASE_WORD && word < SEL_BASE_WORD + num_sel_regs)
      return ACC_SEL;
    else if (word == COMP_WORD)
      return ACC_COMP;
    else
      return ACC_NONE;
  endfunction

  // True when a port code names an existing port.
  function automatic logic code_in_range(input int code, input int num_ports);
    return (code < num_ports);
  endfunction
endpackage

// File: rtl/irqsel_regs.sv
module irqsel_regs
  import irq_src_select_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int SEL_W     = 4,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  input  logic                       ready_in,
  output logic [NUM_LINES*SEL_W-1:0] sel_flat,
  output logic                       en_out,
  output logic [DATA_W-1:0]          rd_data
);
  localparam int LPR      = SEL_SPAN / SEL_W;
  localparam int NUM_REGS = NUM_LINES / LPR;
  localparam int WORD_W   = ADDR_W - 2;

  logic [WORD_W-1:0] wr_word;
  logic [WORD_W-1:0] rd_word;
  acc_kind_e         wr_kind;
  acc_kind_e         rd_kind;

  assign wr_word = wr_addr[ADDR_W-1:2];
  assign rd_word = rd_addr[ADDR_W-1:2];
  assign wr_kind = classify_word(int'(wr_word), NUM_REGS);
  assign rd_kind = classify_word(int'(rd_word), NUM_REGS);

  // Address bits 1:0 and data above the code span do not reach any storage.
  logic unused_bits;
  assign unused_bits = ^{wr_addr[1:0], rd_addr[1:0], wr_data[DATA_W-1:SEL_SPAN]};

  // One code register per line, each decoding its own word and field.
  for (genvar l = 0; l < NUM_LINES; l++) begin : g_sel
    localparam int MY_WORD = SEL_BASE_WORD + l / LPR;
    localparam int MY_LSB  = (l % LPR) * SEL_W;
    logic hit;
    assign hit = wr_en && (wr_kind == ACC_SEL) && (int'(wr_word) == MY_WORD);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sel_flat[l*SEL_W +: SEL_W] <= '0;
      else if (hit)
        sel_flat[l*SEL_W +: SEL_W] <= wr_data[MY_LSB +: SEL_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      en_out <= 1'b0;
    else if (wr_en && (wr_kind == ACC_COMP))
      en_out <= wr_data[COMP_EN_BIT];
  end

  always_comb begin
    rd_data = '0;
    unique case (rd_kind)
      ACC_SEL: begin
        for (int l = 0; l < NUM_LINES; l++) begin
          if (SEL_BASE_WORD + l / LPR == int'(rd_word))
            rd_data[(l % LPR)*SEL_W +: SEL_W] = sel_flat[l*SEL_W +: SEL_W];
        end
      end
      ACC_COMP: begin
        rd_data[COMP_EN_BIT]  = en_out;
        rd_data[COMP_RDY_BIT] = ready_in;
      end
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/irqsel_route.sv
module irqsel_route
  import irq_src_select_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int NUM_PORTS = 8,
  parameter int SEL_W     = 4
) (
  input  logic [NUM_PORTS*NUM_LINES-1:0] port_pins,
  input  logic [NUM_LINES*SEL_W-1:0]     sel_flat,
  output logic [NUM_LINES-1:0]           irq_line
);
  localparam int PIDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  for (genvar x = 0; x < NUM_LINES; x++) begin : g_line
    logic [NUM_PORTS-1:0] column;   // pin x of every port
    logic [SEL_W-1:0]     code;
    logic                 valid;
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_col
      assign column[p] = port_pins[p*NUM_LINES + x];
    end
    assign code  = sel_flat[x*SEL_W +: SEL_W];
    assign valid = code_in_range(int'(code), NUM_PORTS);
    assign irq_line[x] = valid ? column[code[PIDX_W-1:0]] : 1'b0;
  end
endmodule

// File: rtl/irqsel_comp_timer.sv
module irqsel_comp_timer #(
  parameter int READY_DELAY = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic ready
);
  localparam int CNT_W = $clog2(READY_DELAY + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(READY_DELAY - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!en) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      if (cnt == LAST)
        ready <= 1'b1;
      else
        cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/irq_src_select.sv
module irq_src_select
  import irq_src_select_pkg::*;
#(
  parameter int NUM_LINES   = 16,
  parameter int NUM_PORTS   = 8,
  parameter int SEL_W       = 4,
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 32,
  parameter int READY_DELAY = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_PORTS*NUM_LINES-1:0] port_pins,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic [ADDR_W-1:0]              rd_addr,
  output logic [DATA_W-1:0]              rd_data,
  output logic [NUM_LINES-1:0]           irq_line,
  output logic                           comp_en,
  output logic                           comp_ready
);
  // Named internal wires, visible to the bound checker.
  logic [NUM_LINES*SEL_W-1:0] sel_flat;

  irqsel_regs #(
    .NUM_LINES(NUM_LINES), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .ready_in(comp_ready),
    .sel_flat(sel_flat), .en_out(comp_en), .rd_data(rd_data)
  );

  irqsel_route #(
    .NUM_LINES(NUM_LINES), .NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)
  ) u_route (
    .port_pins(port_pins), .sel_flat(sel_flat), .irq_line(irq_line)
  );

  irqsel_comp_timer #(
    .READY_DELAY(READY_DELAY)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .en(comp_en), .ready(comp_ready)
  );
endmodule

// File: rtl/irq_src_select_chk.sv
module irq_src_select_chk
  import irq_src_select_pkg::*;
#(
  parameter int NUM_LINES   = 16,
  parameter int NUM_PORTS   = 8,
  parameter int SEL_W       = 4,
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 32,
  parameter int READY_DELAY = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_en,
  input logic [ADDR_W-1:0]          wr_addr,
  input logic [DATA_W-1:0]          wr_data,
  input logic [ADDR_W-1:0]          rd_addr,
  input logic [DATA_W-1:0]          rd_data,
  input logic [NUM_LINES-1:0]       irq_line,
  input logic                       comp_en,
  input logic                       comp_ready,
  input logic [NUM_LINES*SEL_W-1:0] sel_flat
);
  localparam int LPR      = SEL_SPAN / SEL_W;
  localparam int NUM_REGS = NUM_LINES / LPR;
  localparam int CW       = $clog2(READY_DELAY + 1);

  acc_kind_e wk, rk;
  assign wk = classify_word(int'(wr_addr[ADDR_W-1:2]), NUM_REGS);
  assign rk = classify_word(int'(rd_addr[ADDR_W-1:2]), NUM_REGS);

  // Counts clock edges with the enable held, saturating at the delay.
  logic [CW-1:0] en_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                en_cnt <= '0;
    else if (!comp_en)                         en_cnt <= '0;
    else if (en_cnt != CW'(READY_DELAY))       en_cnt <= en_cnt + 1'b1;
  end

  // R3
  for (genvar x = 0; x < NUM_LINES; x++) begin : g_bad
    bad_code_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(sel_flat[x*SEL_W +: SEL_W]) >= NUM_PORTS) |-> !irq_line[x]);
  end

  // R4 / R5
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_wr
    sel_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(wr_addr[ADDR_W-1:2]) == SEL_BASE_WORD + r)
      |=> sel_flat[r*LPR*SEL_W +: LPR*SEL_W] == $past(wr_data[LPR*SEL_W-1:0]));
  end

  // R4
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rk == ACC_SEL) |-> rd_data[DATA_W-1:SEL_SPAN] == '0);

  // R7
  ready_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(comp_ready) |-> en_cnt == CW'(READY_DELAY));

  // R7
  ready_reach_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_en && en_cnt == CW'(READY_DELAY)) |-> comp_ready);

  // R8
  ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !comp_en |=> !comp_ready);

  // R9
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wk == ACC_NONE) |=> ($stable(sel_flat) && $stable(comp_en)));

  // R9
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rk == ACC_NONE) |-> rd_data == '0);

  logic unused_chk;
  assign unused_chk = ^{wr_data[DATA_W-1:LPR*SEL_W]};
endmodule

bind irq_src_select irq_src_select_chk #(
  .NUM_LINES(NUM_LINES), .NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W),
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .READY_DELAY(READY_DELAY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
  .irq_line(irq_line), .comp_en(comp_en), .comp_ready(comp_ready),
  .sel_flat(sel_flat)
);

// File: tb/irq_src_select_test.sv
module irq_src_select_test;
  localparam int RD = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] port_pins = '0;
  logic         wr_en = 1'b0;
  logic [5:0]   wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic [5:0]   rd_addr = '0;
  logic [31:0]  rd_data;
  logic [15:0]  irq_line;
  logic         comp_en, comp_ready;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [3:0] m_sel [16];   // bench model of the codes

  always #2 clk = ~clk;     // 250 MHz

  irq_src_select #(.READY_DELAY(RD)) uut (
    .clk(clk), .rst_n(rst_n), .port_pins(port_pins), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_line(irq_line), .comp_en(comp_en), .comp_ready(comp_ready)
  );

  function automatic logic [15:0] exp_lines(input logic [127:0] pins);
    logic [15:0] v;
    for (int x = 0; x < 16; x++)
      v[x] = (m_sel[x] < 4'd8) ? pins[int'(m_sel[x]) * 16 + x] : 1'b0;
    return v;
  endfunction

  function automatic logic [31:0] exp_sel_reg(input int r);
    logic [31:0] v = '0;
    for (int k = 0; k < 4; k++) v[k*4 +: 4] = m_sel[r*4 + k];
    return v;
  endfunction

  function automatic logic [127:0] rnd_pins();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wr_sel(input int r, input logic [31:0] d);
    wr(6'(8 + 4*r), d);
    for (int k = 0; k < 4; k++) m_sel[r*4 + k] = d[k*4 +: 4];
  endtask

  task automatic check_all_regs(input string req);
    logic [31:0] d;
    for (int r = 0; r < 4; r++) begin
      rd(6'(8 + 4*r), d);
      check(req, d, exp_sel_reg(r));
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    int n;
    void'($urandom(32'd7321));
    for (int x = 0; x < 16; x++) m_sel[x] = '0;
    port_pins = rnd_pins();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_all_regs("R1");
    rd(6'h20, d);
    check("R1 comp word", d, 32'h0);
    check("R1 flags", {30'd0, comp_en, comp_ready}, 32'h0);
    check("R1 port A", 32'(irq_line), 32'(port_pins[15:0]));

    // R2 uniform codes
    for (int c = 0; c < 8; c++) begin
      for (int r = 0; r < 4; r++) wr_sel(r, {16'h0, {4{4'(c)}}});
      port_pins = rnd_pins();
      #1;
      check("R2 uniform", 32'(irq_line), 32'(port_pins[c*16 +: 16]));
    end
    // R2 distinct codes per line
    for (int r = 0; r < 4; r++)
      wr_sel(r, {16'h0, 4'((r*4+3) % 8), 4'((r*4+2) % 8), 4'((r*4+1) % 8), 4'((r*4) % 8)});
    port_pins = rnd_pins();
    #1;
    check("R2 distinct", 32'(irq_line), 32'(exp_lines(port_pins)));

    // R3 out-of-range codes with all pins high
    for (int r = 0; r < 4; r++) wr_sel(r, 32'h0000_FBA8);
    port_pins = '1;
    #1;
    check("R3 high codes", 32'(irq_line), 32'h0);

    // R4 layout and reserved bits
    wr_sel(0, 32'hFFFF_3210);
    wr_sel(1, 32'hABCD_7654);
    wr_sel(2, 32'h1234_0123);
    wr_sel(3, 32'h8000_4567);
    check_all_regs("R4");
    port_pins = rnd_pins();
    #1;
    check("R4 lines", 32'(irq_line), 32'(exp_lines(port_pins)));

    // R5 write timing and combinational routing
    @(negedge clk);
    port_pins = rnd_pins();
    wr_en = 1'b1; wr_addr = 6'h08; wr_data = 32'h0000_5555;
    #1;
    check("R5 before edge", 32'(irq_line), 32'(exp_lines(port_pins)));
    @(negedge clk);
    wr_en = 1'b0;
    for (int k = 0; k < 4; k++) m_sel[k] = 4'h5;
    check("R5 after edge", 32'(irq_line), 32'(exp_lines(port_pins)));
    port_pins = ~port_pins;
    #1;
    check("R5 comb", 32'(irq_line), 32'(exp_lines(port_pins)));

    // R7 bit 8 write ignored while disabled
    wr(6'h20, 32'h0000_0100);
    repeat (RD + 2) @(negedge clk);
    rd(6'h20, d);
    check("R7 bit8 ignored", d, 32'h0);

    // R6 / R7 enable and ready delay
    wr(6'h20, 32'h0000_0001);
    check("R6 comp_en", 32'(comp_en), 32'h1);
    n = 0;
    while (!comp_ready && n < 100) begin
      @(negedge clk);
      n++;
    end
    check("R7 delay", n, RD);
    rd(6'h20, d);
    check("R7 read", d, 32'h0000_0101);
    wr(6'h20, 32'h0000_0001);
    check("R7 no restart", 32'(comp_ready), 32'h1);

    // R8 clear timing
    wr(6'h20, 32'h0);
    check("R8 still set", {30'd0, comp_en, comp_ready}, 32'h1);
    @(negedge clk);
    check("R8 cleared", 32'(comp_ready), 32'h0);

    // R9 unmapped offsets
    for (int a = 0; a < 64; a += 4) begin
      if (!(a == 8 || a == 12 || a == 16 || a == 20 || a == 32)) begin
        wr(6'(a), 32'hFFFF_FFFF);
        rd(6'(a), d);
        check("R9 read zero", d, 32'h0);
      end
    end
    check_all_regs("R9");
    rd(6'h20, d);
    check("R9 comp", d, 32'h0);

    // R2/R3/R4 random mix
    for (int i = 0; i < 300; i++) begin
      port_pins = rnd_pins();
      if ($urandom_range(0, 2) != 0) wr_sel($urandom_range(0, 3), $urandom());
      else @(negedge clk);
      #1;
      check("R2 random", 32'(irq_line), 32'(exp_lines(port_pins)));
      n = $urandom_range(0, 3);
      rd(6'(8 + 4*n), d);
      check("R4 random", d, exp_sel_reg(n));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule